// File: doc/BRIEF.md
# Batch-Input Single-Output FIFO

This block is a bounded first-in first-out buffer whose producer may deliver a whole group of values in a single clock cycle, while the consumer side releases at most one value per cycle. The write side has `LANES` parallel data lanes and a count that says how many of them, starting from lane 0, hold a value this cycle. Every counted value is enqueued in the cycle it is presented, unless the buffer has no room for it.

The read side has no enable. On every clock edge the oldest available value moves into a registered output stage, and a valid flag goes with it. When nothing is stored and nothing arrives, the valid flag is low and the data output reads zero. A value that arrives at an empty buffer appears at the output exactly one cycle later, because the output register can be loaded straight from lane 0. Capacity is a parameter. The number of stored entries is visible on a level output. Values that do not fit are dropped, and a sticky overflow flag records the loss.

Top module: `batch_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block empties: after that edge `out_valid` is 0, `out_data` is 0, `level` is 0 and `overflow` is 0.
- R2: Values leave in arrival order. Within one group, lane 0 (bits `DW-1:0` of `in_lanes`) leaves first, and lane k (bits `k*DW +: DW`) leaves before lane k+1. Groups from earlier cycles leave before groups from later cycles.
- R3: A value presented before edge n can appear on `out_data` no earlier than after edge n. When the buffer is empty, lane 0 of a group appears after the very next edge. At most one value leaves per edge.
- R4: If no entries are stored and `in_count` is 0 before an edge, then after that edge `out_valid` is 0 and `out_data` is 0.
- R5: `level` never exceeds `DEPTH`. The room for new values at an edge is `DEPTH - level`, plus one when a value leaves at that edge. A group larger than this room keeps only its lowest lanes and discards the rest.
- R6: Discarding any value sets `overflow` after that edge. Once set, `overflow` stays 1 until reset.
- R7: At each edge `level` becomes `level + accepted - left`, where `left` is 1 if a value moved to the output. A value leaving and a group arriving in the same cycle are both honoured.
- R8: An `in_count` larger than `LANES` is treated as `LANES`.
- R9: Lanes at or above `in_count` are ignored. Their contents never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_count | input | CW | Number of valid lanes this cycle, lanes taken from 0 upward |
| in_lanes | input | LANES*DW | Packed lane data, lane k at bits k*DW +: DW |
| out_valid | output | 1 | High when out_data carries a value |
| out_data | output | DW | Registered output value, zero when absent |
| level | output | LW | Number of stored entries, not counting the one on the output |
| overflow | output | 1 | Sticky flag, set when any value was discarded |

## Verification
A read or write pointer that is off by one shows up on `out_data` as a value out of sequence. This becomes visible as soon as the damaged slot reaches the head, which takes at most `level + 1` cycles. An occupancy count that drifts from the pointers is visible on `level` at the next sample. It then shows as `out_valid` dropping too early or rising when nothing is stored. An error in the room calculation shows in the edge where the buffer fills: the lane that survives or is dropped is wrong, `level` goes past `DEPTH`, or `overflow` rises when no value was lost.

// File: rtl/batch_fifo_pkg.sv
// Package: shared helpers for the batch-input FIFO.
// Assumes all ring arithmetic operands are below the ring size.
package batch_fifo_pkg;

    // Advance a ring index by an offset no larger than the ring size.
    function automatic int ring_step(input int ptr, input int off, input int depth);
        int sum;
        sum = ptr + off;
        if (sum >= depth) begin
            sum = sum - depth;
        end
        return sum;
    endfunction

endpackage

// File: rtl/batch_fifo_admit.sv
// Module: batch_fifo_admit
// Decides each cycle whether a value leaves the buffer and how many
// incoming lanes fit. Lanes beyond the room are dropped from the top.
// Assumes LANES <= DEPTH, and that level is the registered occupancy.
module batch_fifo_admit #(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int CW    = 3,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wr_count,
    input  logic [LW-1:0] level,
    output logic [CW-1:0] take,
    output logic          pop,
    output logic          drop
);
    localparam int SW = LW + 1;

    logic [CW-1:0] req;
    logic [SW-1:0] room;

    // Clamp the requested lane count to the number of lanes present.
    always_comb begin
        req = (wr_count > CW'(LANES)) ? CW'(LANES) : wr_count;
    end

    // A value leaves whenever anything is stored or arriving.
    always_comb begin
        pop = (level != '0) || (req != '0);
    end

    // Room counts the slot freed by a same-cycle departure.
    always_comb begin
        room = SW'(DEPTH) - SW'(level) + SW'(pop);
        drop = (SW'(req) > room);
        take = drop ? CW'(room) : req;
    end

    // R5
    take_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take <= wr_count) && (take <= CW'(LANES)));

    // R8
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count > CW'(LANES)) && (level == '0) |-> (take == CW'(LANES)));

endmodule

// File: rtl/batch_fifo_store.sv
// Module: batch_fifo_store
// Ring storage with LANES write ports into consecutive slots and one
// read port at the head. The head advances on every departure, including
// when lane 0 bypasses to the output. The copy written to the ring then
// gets skipped.
// Assumes take <= LANES <= DEPTH.
module batch_fifo_store #(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 3,
    parameter int LW    = 4,
    parameter int AW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES*DW-1:0] lanes,
    input  logic [CW-1:0]       take,
    input  logic                pop,
    input  logic [LW-1:0]       level,
    output logic [DW-1:0]       head_data
);
    import batch_fifo_pkg::*;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head;
    logic [AW-1:0] tail;
    logic [AW-1:0] slot [LANES];
    int            gap;

    // Slot address for each lane, counted from the tail.
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        assign slot[g] = AW'(ring_step(int'(tail), g, DEPTH));
    end

    // Move head and tail by the departures and accepted lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (pop) begin
                head <= AW'(ring_step(int'(head), 1, DEPTH));
            end
            tail <= AW'(ring_step(int'(tail), int'(take), DEPTH));
        end
    end

    // Write each accepted lane into its slot.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (CW'(l) < take) begin
                mem[slot[l]] <= lanes[l*DW +: DW];
            end
        end
    end

    // Present the oldest stored value.
    always_comb begin
        head_data = mem[head];
    end

    // Pointer distance, used only to cross-check the occupancy count.
    always_comb begin
        gap = (tail >= head) ? int'(tail) - int'(head)
                             : int'(tail) + DEPTH - int'(head);
    end

    // R7
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap == (int'(level) % DEPTH));

endmodule

// File: rtl/batch_fifo_out.sv
// Module: batch_fifo_out
// Registered output stage and sticky overflow flag. It loads the head
// entry, or lane 0 when nothing is stored, and shows zero when absent.
// Assumes pop is high only when a value is available.
module batch_fifo_out #(
    parameter int DW = 8,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [LW-1:0] level,
    input  logic [DW-1:0] head_data,
    input  logic [DW-1:0] lane0,
    input  logic          drop,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          overflow
);
    // Load the oldest available value, or mark the output absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pop;
            if (!pop) begin
                out_data <= '0;
            end else if (level != '0) begin
                out_data <= head_data;
            end else begin
                out_data <= lane0;
            end
        end
    end

    // Remember any discarded value until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/batch_fifo.sv
// Module: batch_fifo
// Bounded FIFO taking up to LANES values per cycle and releasing one per
// cycle through a registered output. It holds the occupancy count and
// wires the admit, storage and output stages together.
// Assumes 1 <= LANES <= DEPTH.
module batch_fifo #(
    parameter  int LANES = 4,
    parameter  int DEPTH = 8,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(LANES + 1),
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       in_count,
    input  logic [LANES*DW-1:0] in_lanes,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic [LW-1:0]       level,
    output logic                overflow
);
    logic [CW-1:0] take;
    logic          pop;
    logic          drop;
    logic [DW-1:0] head_data;
    logic [LW:0]   lvl_next;

    batch_fifo_admit #(
        .LANES(LANES), .DEPTH(DEPTH), .CW(CW), .LW(LW)
    ) u_admit (
        .clk(clk), .rst_n(rst_n), .wr_count(in_count), .level(level),
        .take(take), .pop(pop), .drop(drop)
    );

    batch_fifo_store #(
        .LANES(LANES), .DEPTH(DEPTH), .DW(DW), .CW(CW), .LW(LW), .AW(AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .lanes(in_lanes), .take(take),
        .pop(pop), .level(level), .head_data(head_data)
    );

    batch_fifo_out #(
        .DW(DW), .LW(LW)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .pop(pop), .level(level),
        .head_data(head_data), .lane0(in_lanes[DW-1:0]), .drop(drop),
        .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
    );

    // Next occupancy: add accepted lanes, remove the departing value.
    always_comb begin
        lvl_next = {1'b0, level} + (LW+1)'(take) - (LW+1)'(pop);
    end

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= lvl_next[LW-1:0];
        end
    end

    // R5
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R4
    idle_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) && (in_count == '0) |=> !out_valid && (out_data == '0));

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) && (in_count != '0) |=>
        out_valid && (out_data == $past(in_lanes[DW-1:0])));

    // R6
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overflow);

endmodule

// File: tb/test_batch_fifo.sv
module test_batch_fifo;
    localparam int PERIOD = 10;
    localparam int LANES  = 4;
    localparam int DEPTH  = 8;
    localparam int DW     = 8;
    localparam int CW     = $clog2(LANES + 1);
    localparam int LW     = $clog2(DEPTH + 1);
    localparam int N      = 22;

    localparam logic [CW-1:0] T_CNT [N] = '{
        3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 3'd0, 3'd1, 3'd4, 3'd4, 3'd4, 3'd4,
        3'd0, 3'd2, 3'd0, 3'd0, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0
    };
    localparam logic [31:0] T_DAT [N] = '{
        32'hEEEEEE11, 32'hDDDDDDDD, 32'hEEEE2221, 32'hEE333231, 32'h44434241,
        32'h0F0F0F0F, 32'hCCCCCC51, 32'h64636261, 32'h74737271, 32'h84838281,
        32'h94939291, 32'h00000000, 32'hBBBBA2A1, 32'h0, 32'h0, 32'hEEC3C2C1,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CW-1:0]       in_count = '0;
    logic [LANES*DW-1:0] in_lanes = '0;
    logic                out_valid;
    logic [DW-1:0]       out_data;
    logic [LW-1:0]       level;
    logic                overflow;

    int            errs = 0;
    int            checks = 0;
    logic [DW-1:0] mq [$];
    bit            movf = 1'b0;
    bit            exp_v;
    logic [DW-1:0] exp_d;

    batch_fifo #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) i_batch_fifo (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_lanes(in_lanes),
        .out_valid(out_valid), .out_data(out_data), .level(level),
        .overflow(overflow)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // Drive one cycle, update the model at the edge, compare at the negedge.
    task automatic cycle(input logic [CW-1:0] cnt, input logic [31:0] dat);
        int  n;
        int  room;
        int  acc;
        bit  leave;
        in_count = cnt;
        in_lanes = dat;
        @(posedge clk);
        n     = (int'(cnt) > LANES) ? LANES : int'(cnt);   // R8
        leave = (mq.size() > 0) || (n > 0);
        room  = DEPTH - mq.size() + (leave ? 1 : 0);
        acc   = (n > room) ? room : n;                      // R5
        if (n > acc) movf = 1'b1;
        for (int k = 0; k < acc; k++) mq.push_back(dat[k*DW +: DW]);
        exp_v = leave;
        exp_d = leave ? mq.pop_front() : '0;
        @(negedge clk);
        chk(out_valid == exp_v, "R4", "out_valid", 32'(out_valid), 32'(exp_v));
        chk(out_data == exp_d, "R2", "out_data", 32'(out_data), 32'(exp_d));
        chk(int'(level) == mq.size(), "R7", "level", 32'(level), 32'(mq.size()));
        chk(level <= LW'(DEPTH), "R5", "level cap", 32'(level), 32'(DEPTH));
        chk(overflow == movf, "R6", "overflow", 32'(overflow), 32'(movf));
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_count = '0;
        in_lanes = 32'hFFFFFFFF;
        @(negedge clk);
        @(negedge clk);
        mq.delete();
        movf = 1'b0;
        // R1
        chk(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 0);
        chk(out_data == '0, "R1", "out_data", 32'(out_data), 0);
        chk(level == '0, "R1", "level", 32'(level), 0);
        chk(overflow == 1'b0, "R1", "overflow", 32'(overflow), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 100000);
        checks++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // Table walk: ordering, partial groups, fill and overflow (R2, R9).
        for (int i = 0; i < N; i++) cycle(T_CNT[i], T_DAT[i]);

        // R6: overflow stays set across idle cycles.
        cycle(3'd0, 32'h0);
        chk(overflow == 1'b1, "R6", "sticky overflow", 32'(overflow), 1);

        // R1: reset clears everything after a full, overflowed state.
        for (int i = 0; i < 4; i++) cycle(3'd4, 32'h0D0C0B0A + 32'(i));
        do_reset();

        // R3: a single value into an empty FIFO appears after one edge.
        cycle(3'd1, 32'hFFFFFF5A);
        chk(out_valid && out_data == 8'h5A, "R3", "bypass data",
            32'(out_data), 32'h5A);
        chk(level == '0, "R3", "bypass level", 32'(level), 0);

        // R3: a group of four drains one value per cycle.
        cycle(3'd4, 32'h24232221);
        cycle(3'd0, 32'h0);
        chk(out_data == 8'h22 && level == LW'(2), "R3", "one per cycle",
            32'(out_data), 32'h22);
        cycle(3'd0, 32'h0);
        cycle(3'd0, 32'h0);
        cycle(3'd0, 32'h0);

        // R8: a count above LANES behaves as LANES.
        cycle(3'd7, 32'h34333231);
        chk(level == LW'(3), "R8", "clamped level", 32'(level), 3);

        // R7: a departure and a write in the same cycle leave the level unchanged.
        cycle(3'd1, 32'h00000041);
        chk(level == LW'(3), "R7", "balanced level", 32'(level), 3);

        // R9: lanes above the count never appear at the output.
        for (int i = 0; i < 6; i++) cycle(3'd0, 32'hEEEEEEEE);
        chk(!out_valid && out_data == '0, "R9", "drained absent",
            32'(out_data), 0);

        summary();
        $finish;
    end
endmodule